// File: doc/BRIEF.md
# Virtually indexed, physically tagged set-associative data cache

This block is a set-associative data cache that picks its set from address bits that translation leaves unchanged. A request carries only the page-offset part of the address. The cache selects the set from those bits at once, while an external translation unit works on the page number. One cycle after a request is accepted, the translation unit presents the physical page number. The cache then compares that number against the physical tag held in every way of the selected set. Because the set index plus the line offset exactly fills the page offset, more capacity comes only from more ways: W ways of 2^(page bits) bytes each.

Reads that miss fetch the whole line over a refill port. The line is placed in a free way, or in the pseudo-LRU way when no way is free, and the requested word is then returned. Stores are write-through: every store goes to memory. A store that misses does not allocate a line. A flush input drops every cached line in one cycle.

Top module: `vipt_cache`

## Requirements
- R1: The set index is word-offset bits [PAGE_BITS-3:2] of `req_woff`, and the word within the line is bits [1:0]. No page-number bit takes part in set selection, so one physical page number can occupy every set at once.
- R2: `tlb_ppn` is sampled only in the cycle after a request is accepted, and its value in any other cycle has no effect. In the cycle after acceptance, neither `resp_valid` nor `mem_req_valid` is asserted. A read hit raises `resp_valid` in the following cycle, with no memory traffic.
- R3: A request hits exactly when some valid way of its set holds a tag equal to the sampled page number. All four ways of a set can hold lines of different page numbers at the same time.
- R4: A read miss holds `mem_req_valid` with `mem_req_write`=0 and `mem_addr` = {ppn, set, 4'b0000}. It accepts LINE_WORDS `fill_valid` beats in ascending word order, which may have gaps between them. It installs the line and then responds with `resp_hit`=0 and the requested word.
- R5: A read miss replaces the lowest-numbered invalid way. If every way is valid, it replaces the way named by a three-node tree pseudo-LRU. Each read hit, write hit and completed fill sets every node on the accessed way's path to point at the other subtree.
- R6: A write hit updates the cached word and holds a memory write with `mem_addr` = {ppn, set, word, 2'b00} and `mem_wdata` until `mem_ack`. It then responds with `resp_hit`=1, and later reads return the new data.
- R7: A write miss sends the same memory write but installs nothing: it responds with `resp_hit`=0, and a later read of that line misses.
- R8: `flush` asserted while the cache is idle invalidates every line, and `req_ready` is low while `flush` is high.
- R9: After reset the cache is idle, with `req_ready`=1 and no response or memory request. `req_ready` is low whenever a request is in progress, and `resp_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all lines (taken while idle) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_woff | input | PAGE_BITS-2 | Word address within the page |
| req_wdata | input | DATA_W | Store data |
| tlb_ppn | input | PPN_W | Physical page number, valid one cycle after acceptance |
| resp_valid | output | 1 | Completion pulse |
| resp_hit | output | 1 | Access hit in the cache |
| resp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request held |
| mem_req_write | output | 1 | 1 = word write, 0 = line fill |
| mem_addr | output | PPN_W+PAGE_BITS | Physical byte address |
| mem_wdata | output | DATA_W | Write-through data |
| mem_ack | input | 1 | Memory write done |
| fill_valid | input | 1 | Refill beat present |
| fill_data | input | DATA_W | Refill word |

## Verification
The hardest state to reach from the ports is a full set whose pseudo-LRU tree has been reshaped by hits in an irregular order, because only then does the replacement choice depend on the tree. The bench first fills every set, then drives a long pseudo-random stream that confines six page numbers to four sets and mixes in stores. Every hit or miss is predicted by a tag-and-tree model. To show that the page number is not taken from the request cycle or the cycle after, the bench drives a wrong `tlb_ppn` during the request cycle and again after the translation cycle.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOOK  = 2'd1,
      ST_FILL  = 2'd2,
      ST_WRITE = 2'd3
   } vipt_state_e;
endpackage

// File: rtl/vipt_plru.sv
// Per-set replacement state; a tree for power-of-two ways, a constant for one way.
module vipt_plru #(
   parameter int WAYS = 4,
   parameter int SETS = 16,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] sel_set,
   input  logic             upd_en,
   input  logic [WAY_W-1:0] upd_way,
   output logic [WAY_W-1:0] victim
);
   generate
      if (WAYS == 1) begin : g_single
         assign victim = '0;
      end else begin : g_tree
         logic [WAYS-2:0] tree_q [SETS];
         logic [WAYS-2:0] upd_mask, upd_val;

         // walk from the root following the stored pointers
         always_comb begin
            int node;
            victim = '0;
            node   = 1;
            for (int lv = 0; lv < WAY_W; lv++) begin
               victim = (victim << 1) | WAY_W'(tree_q[sel_set][node-1]);
               node   = 2 * node + int'(tree_q[sel_set][node-1]);
            end
         end

         // nodes on the touched path point away from it
         always_comb begin
            int unode;
            upd_mask = '0;
            upd_val  = '0;
            unode    = 1;
            for (int lv = 0; lv < WAY_W; lv++) begin
               upd_mask[unode-1] = 1'b1;
               upd_val[unode-1]  = ~upd_way[WAY_W-1-lv];
               unode = 2 * unode + int'(upd_way[WAY_W-1-lv]);
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
            end else if (upd_en) begin
               tree_q[sel_set] <= (tree_q[sel_set] & ~upd_mask) | (upd_val & upd_mask);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vipt_match.sv
// Parallel physical-tag compare across all ways of one set.
module vipt_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 8,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]       way_vld,
   input  logic [WAYS*TAG_W-1:0] way_tags,
   input  logic [TAG_W-1:0]      ppn,
   output logic                  hit,
   output logic [WAY_W-1:0]      hit_way
);
   logic [WAYS-1:0] eq;

   generate
      for (genvar g = 0; g < WAYS; g++) begin : g_cmp
         assign eq[g] = way_vld[g] && (way_tags[g*TAG_W +: TAG_W] == ppn);
      end
   endgenerate

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (eq[w]) hit_way = WAY_W'(w);
      end
   end

   assign hit = |eq;
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
   parameter int PAGE_BITS  = 8,
   parameter int LINE_BYTES = 16,
   parameter int WAYS       = 4,
   parameter int PPN_W      = 8,
   parameter int DATA_W     = 32,
   localparam int WORD_BYTES = DATA_W / 8,
   localparam int BYTE_W     = $clog2(WORD_BYTES),
   localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES,
   localparam int WSEL_W     = $clog2(LINE_WORDS),
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int IDX_W      = PAGE_BITS - OFF_W,
   localparam int SETS       = 1 << IDX_W,
   localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int WOFF_W     = PAGE_BITS - BYTE_W,
   localparam int PA_W       = PPN_W + PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [WOFF_W-1:0] req_woff,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [PPN_W-1:0]  tlb_ppn,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [DATA_W-1:0] resp_rdata,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [PA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data
);
   import vipt_pkg::*;

   generate
      if (WAYS < 1 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("vipt_cache: WAYS must be a power of two");
      end
      if (DATA_W % 8 != 0 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("vipt_cache: DATA_W must be a power-of-two number of bytes");
      end
      if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_WORDS < 2) begin : g_bad_line
         $error("vipt_cache: line must be a power of two of at least two words");
      end
      if (OFF_W >= PAGE_BITS) begin : g_bad_page
         $error("vipt_cache: set index and line offset must fit in the page offset");
      end
   endgenerate

   vipt_state_e state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WSEL_W-1:0] wsel_q, cnt_q;
   logic              wr_q, hit_q, rsp_v_q, rsp_h_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic [PPN_W-1:0]  ppn_q;
   logic [WAY_W-1:0]  way_q;

   logic [DATA_W-1:0] data_q [WAYS][SETS][LINE_WORDS];
   logic [PPN_W-1:0]  tag_q  [WAYS][SETS];
   logic [SETS-1:0]   vld_q  [WAYS];

   logic [WAYS-1:0]       way_vld;
   logic [WAYS*PPN_W-1:0] set_tags;
   logic                  hit, free_any, fill_last, plru_upd;
   logic [WAY_W-1:0]      hit_way, free_way, lru_way, pick_way, plru_way;

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         way_vld[w]                  = vld_q[w][idx_q];
         set_tags[w*PPN_W +: PPN_W]  = tag_q[w][idx_q];
      end
   end

   vipt_match #(.WAYS(WAYS), .TAG_W(PPN_W)) u_match (
      .way_vld  (way_vld),
      .way_tags (set_tags),
      .ppn      (tlb_ppn),
      .hit      (hit),
      .hit_way  (hit_way)
   );

   always_comb begin
      free_any = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!way_vld[w]) begin
            free_any = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   assign pick_way  = free_any ? free_way : lru_way;
   assign fill_last = (state_q == ST_FILL) && fill_valid && (cnt_q == WSEL_W'(LINE_WORDS - 1));
   assign plru_upd  = ((state_q == ST_LOOK) && hit) || fill_last;
   assign plru_way  = (state_q == ST_LOOK) ? hit_way : way_q;

   vipt_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_set (idx_q),
      .upd_en  (plru_upd),
      .upd_way (plru_way),
      .victim  (lru_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         wsel_q  <= '0;
         cnt_q   <= '0;
         wr_q    <= 1'b0;
         hit_q   <= 1'b0;
         wdata_q <= '0;
         rdata_q <= '0;
         ppn_q   <= '0;
         way_q   <= '0;
         rsp_v_q <= 1'b0;
         rsp_h_q <= 1'b0;
         for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (flush) begin
                  for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
               end else if (req_valid) begin
                  idx_q   <= req_woff[WOFF_W-1:WSEL_W];
                  wsel_q  <= req_woff[WSEL_W-1:0];
                  wr_q    <= req_write;
                  wdata_q <= req_wdata;
                  state_q <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               ppn_q <= tlb_ppn;
               hit_q <= hit;
               way_q <= hit ? hit_way : pick_way;
               cnt_q <= '0;
               if (wr_q) begin
                  state_q <= ST_WRITE;
               end else if (hit) begin
                  rsp_v_q <= 1'b1;
                  rsp_h_q <= 1'b1;
                  rdata_q <= data_q[hit_way][idx_q][wsel_q];
                  state_q <= ST_IDLE;
               end else begin
                  vld_q[pick_way][idx_q] <= 1'b0;
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (fill_valid) begin
                  if (cnt_q == wsel_q) rdata_q <= fill_data;
                  cnt_q <= cnt_q + 1'b1;
                  if (fill_last) begin
                     vld_q[way_q][idx_q] <= 1'b1;
                     rsp_v_q <= 1'b1;
                     rsp_h_q <= 1'b0;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_WRITE: begin
               if (mem_ack) begin
                  rsp_v_q <= 1'b1;
                  rsp_h_q <= hit_q;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // line storage: written by store hits and refill beats
   always_ff @(posedge clk) begin
      if (state_q == ST_LOOK && wr_q && hit) begin
         data_q[hit_way][idx_q][wsel_q] <= wdata_q;
      end
      if (state_q == ST_FILL && fill_valid) begin
         data_q[way_q][idx_q][cnt_q] <= fill_data;
         tag_q[way_q][idx_q]         <= ppn_q;
      end
   end

   assign req_ready     = (state_q == ST_IDLE) && !flush;
   assign resp_valid    = rsp_v_q;
   assign resp_hit      = rsp_h_q;
   assign resp_rdata    = rdata_q;
   assign mem_req_valid = (state_q == ST_FILL) || (state_q == ST_WRITE);
   assign mem_req_write = (state_q == ST_WRITE);
   assign mem_addr      = (state_q == ST_WRITE) ? {ppn_q, idx_q, wsel_q, {BYTE_W{1'b0}}}
                                                : {ppn_q, idx_q, {OFF_W{1'b0}}};
   assign mem_wdata     = wdata_q;
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
   parameter int PA_W   = 16,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              req_valid,
   input logic              req_ready,
   input logic              resp_valid,
   input logic              resp_hit,
   input logic              mem_req_valid,
   input logic              mem_req_write,
   input logic [PA_W-1:0]   mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);
   AST_NO_EARLY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !resp_valid && !mem_req_valid); // R2
   AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_write |-> mem_addr[OFF_W-1:0] == '0); // R4
   AST_MISS_USES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_hit |-> $past(mem_req_valid)); // R7
   AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write && !mem_ack |=>
         mem_req_valid && mem_req_write && $stable(mem_addr) && $stable(mem_wdata)); // R6
   AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !req_ready); // R8
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready); // R9
   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid); // R9
endmodule

bind vipt_cache vipt_cache_chk #(
   .PA_W   (PPN_W + PAGE_BITS),
   .DATA_W (DATA_W),
   .OFF_W  ($clog2(LINE_BYTES))
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .flush         (flush),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .resp_valid    (resp_valid),
   .resp_hit      (resp_hit),
   .mem_req_valid (mem_req_valid),
   .mem_req_write (mem_req_write),
   .mem_addr      (mem_addr),
   .mem_wdata     (mem_wdata),
   .mem_ack       (mem_ack)
);

// File: tb/sim_vipt_cache.sv
module sim_vipt_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [5:0]  req_woff = '0;
   logic [31:0] req_wdata = '0;
   logic [7:0]  tlb_ppn = '0;
   logic        resp_valid, resp_hit;
   logic [31:0] resp_rdata;
   logic        mem_req_valid, mem_req_write;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic        fill_valid = 1'b0;
   logic [31:0] fill_data = '0;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   vipt_cache #(.PAGE_BITS(8), .LINE_BYTES(16), .WAYS(4), .PPN_W(8), .DATA_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_woff(req_woff), .req_wdata(req_wdata), .tlb_ppn(tlb_ppn),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .fill_valid(fill_valid), .fill_data(fill_data)
   );

   // reference state: memory, tags, valids and tree bits
   logic [31:0] mem_m [int];
   bit          m_vld [16][4];
   logic [7:0]  m_tag [16][4];
   logic [2:0]  m_tree [16];

   function automatic logic [31:0] mem_rd(logic [13:0] wa);
      if (mem_m.exists(int'(wa))) return mem_m[int'(wa)];
      return {2'b10, wa, 2'b01, ~wa};
   endfunction

   function automatic int tree_victim(int s);
      if (m_tree[s][0] == 1'b0) return int'(m_tree[s][1]);
      return 2 + int'(m_tree[s][2]);
   endfunction

   task automatic touch(int s, int w);
      m_tree[s][0] = (w < 2) ? 1'b1 : 1'b0;
      if (w < 2) m_tree[s][1] = (w == 0) ? 1'b1 : 1'b0;
      else       m_tree[s][2] = (w == 2) ? 1'b1 : 1'b0;
   endtask

   task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   // one access with memory service; rq names the hit/miss requirement
   task automatic access(bit wr, logic [7:0] ppn, logic [5:0] woff, logic [31:0] wd, string rq);
      int s, ew, cyc, beats;
      bit eh, got, bubble, saw_mem, r_hit;
      logic [31:0] r_data;
      logic [13:0] wa;
      s = int'(woff[5:2]);
      wa = {ppn, woff};
      eh = 1'b0; ew = 0;
      for (int w = 0; w < 4; w++)
         if (m_vld[s][w] && m_tag[s][w] == ppn) begin eh = 1'b1; ew = w; end
      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready when idle", 32'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_woff = woff; req_wdata = wd;
      tlb_ppn = ~ppn;                        // wrong value in the request cycle (R2)
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      tlb_ppn = ppn;
      chk(!resp_valid && !mem_req_valid, "R2", "quiet during translation",
          32'({resp_valid, mem_req_valid}), 0);
      cyc = 0; beats = 0; got = 0; bubble = 0; saw_mem = 0; r_hit = 0; r_data = '0;
      while (!got && cyc < 40) begin
         @(negedge clk);
         cyc++;
         tlb_ppn = ppn ^ 8'h5A;              // wrong value after translation (R2)
         fill_valid = 1'b0; mem_ack = 1'b0;
         if (resp_valid) begin
            got = 1; r_hit = resp_hit; r_data = resp_rdata;
         end else if (mem_req_valid) begin
            saw_mem = 1;
            if (mem_req_write) begin
               chk(mem_addr == {ppn, woff, 2'b00}, "R6", "write address", 32'(mem_addr),
                   32'({ppn, woff, 2'b00}));
               chk(mem_wdata == wd, "R6", "write data", mem_wdata, wd);
               mem_m[int'(wa)] = wd;
               mem_ack = 1'b1;
            end else begin
               if (beats == 0)
                  chk(mem_addr == {ppn, woff[5:2], 4'b0000}, "R4", "fill address",
                      32'(mem_addr), 32'({ppn, woff[5:2], 4'b0000}));
               if (beats == 2 && !bubble) bubble = 1;
               else if (beats < 4) begin
                  fill_valid = 1'b1;
                  fill_data = mem_rd({ppn, woff[5:2], 2'(beats)});
                  beats++;
               end
            end
         end
      end
      fill_valid = 1'b0; mem_ack = 1'b0;
      chk(got, "R9", "response arrived", 32'(got), 1);
      chk(r_hit == eh, rq, "hit flag", 32'(r_hit), 32'(eh));
      chk(saw_mem == (wr || !eh), rq, "memory traffic", 32'(saw_mem), 32'(wr || !eh));
      if (!wr) begin
         chk(r_data == mem_rd(wa), eh ? "R3" : "R4", "read data", r_data, mem_rd(wa));
         if (eh) chk(cyc == 1, "R2", "read hit latency", 32'(cyc), 1);
         else    chk(beats == 4, "R4", "fill beats", 32'(beats), 4);
      end
      // advance the reference
      if (eh) touch(s, ew);
      else if (!wr) begin
         ew = -1;
         for (int w = 3; w >= 0; w--) if (!m_vld[s][w]) ew = w;
         if (ew < 0) ew = tree_victim(s);
         m_vld[s][ew] = 1'b1; m_tag[s][ew] = ppn;
         touch(s, ew);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog cycles=%0d expected below=%0d", cycles, 150000);
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      for (int s = 0; s < 16; s++) begin
         m_tree[s] = '0;
         for (int w = 0; w < 4; w++) begin m_vld[s][w] = 0; m_tag[s][w] = '0; end
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(req_ready && !resp_valid && !mem_req_valid, "R9", "reset state",
          32'({req_ready, resp_valid, mem_req_valid}), 32'h4);

      // R1/R3: four page numbers per set across every set, then all hit
      for (int pass = 0; pass < 2; pass++)
         for (int s = 0; s < 16; s++)
            for (int p = 0; p < 4; p++)
               access(1'b0, 8'h10 + 8'(p * 33), {4'(s), 2'(p)}, '0, "R1");

      // R5: irregular stream over four sets and six page numbers, with stores
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
         access(lfsr[9:7] == 3'd0, 8'h40 + 8'(int'(lfsr[15:10]) % 6),
                {2'b00, lfsr[1:0], lfsr[3:2]}, {16'hD00D, lfsr}, "R5");
      end

      // R6: store hit, then read back
      access(1'b0, 8'h77, 6'b1010_01, '0, "R4");
      access(1'b1, 8'h77, 6'b1010_01, 32'hCAFE_0001, "R6");
      access(1'b0, 8'h77, 6'b1010_01, '0, "R6");
      // R7: store miss leaves no line behind
      access(1'b1, 8'hEE, 6'b1001_11, 32'hBEEF_0002, "R7");
      access(1'b0, 8'hEE, 6'b1001_11, '0, "R7");

      // R8: flush drops every line
      @(negedge clk);
      flush = 1'b1;
      #1 chk(req_ready == 1'b0, "R8", "ready low during flush", 32'(req_ready), 0);
      @(posedge clk);
      @(negedge clk);
      flush = 1'b0;
      for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
      access(1'b0, 8'h77, 6'b1010_01, '0, "R8");
      access(1'b0, 8'h10, 6'b0000_00, '0, "R8");

      // R5: fill order after flush, then tree victim
      for (int p = 1; p <= 5; p++) access(1'b0, 8'(p), 6'b0101_00, '0, "R5");
      for (int p = 1; p <= 5; p++) access(1'b0, 8'(p), 6'b0101_10, '0, "R5");

      summary();
      $finish;
   end
endmodule